// File: doc/BRIEF.md
# Programmable Event Counter Bank

The block holds five independent event counters that software programs through a small word-addressed register port. Each counter picks one of the event inputs through its own selector and passes it through its own filter, which looks at the security attribute that comes with the event. A counter advances once for every clock cycle in which its selected, filtered event input is high. It does so only while its own enable bit and the bank-wide enable bit are both set. Counters can be loaded with any value, so software can place one just below the top of its range and get an overflow after a known number of events.

When a counter wraps from all-ones to zero, it sets a sticky overflow flag. Software can also set or clear these flags through separate set and clear registers, which is useful for save/restore and for testing the interrupt path. One level-sensitive interrupt output is high while any flag is set whose per-counter interrupt enable is also set. A permission gate rejects non-secure register accesses unless one of three things is true: a secure-only allow bit is set, an allow tie-off input is high, or a security-disable input is high. A rejected read returns zero and a rejected write is dropped.

Top module: `ecb_bank`

## Requirements
- R1: After reset, the count-enable mask, the interrupt-enable mask, the overflow flags, the global enable and the non-secure allow bit all read as zero, and `irq` is low. Counter, selector and filter registers have no reset value.
- R2: Counter n (read/write at word address n, for n = 0..4) goes up by one in each cycle where its selected event is high and passes the filter. This happens only when count-enable bit n is set and the global enable (bit 0 at address 30) is set.
- R3: A counter increment from 32'hFFFFFFFF gives 0 and sets overflow flag n. The flags read at address 28 or 29, with bit n for counter n.
- R4: Writing a mask to address 24 sets the count-enable bits that are 1 in the mask. Writing a mask to address 25 clears them. Bits written as 0 are unchanged. The mask reads back at address 24 or 25.
- R5: Writing a mask to address 26 sets interrupt-enable bits, and writing a mask to address 27 clears them, with write-one semantics. The mask reads back at address 26 or 27.
- R6: Writing a mask to address 28 sets overflow flags, and writing a mask to address 29 clears them. If an overflow and a clear hit the same flag in the same cycle, the flag ends up set.
- R7: `irq` is high exactly while some overflow flag and its matching interrupt-enable bit are both set. It stays high until one of the two is cleared, and it also rises after a software write to address 28.
- R8: The filter at address 16+n (bits [1:0]) selects which events count: 0 counts any event, 1 counts only events whose `evt_ns` bit is 0, 2 counts only events whose `evt_ns` bit is 1, and 3 counts nothing.
- R9: The selector at address 8+n (bits [2:0]) picks event input `evt_in[sel]`. Selector values of NUM_EVT (6) or higher never count.
- R10: A non-secure access (`reg_ns`=1) is rejected unless the allow bit, `ns_allow_tie` or `sec_disable` is set. A rejected read returns 0 and a rejected write changes nothing.
- R11: The allow bit (bit 0 at address 31) changes only on secure writes. Non-secure writes to it are ignored even when non-secure access is otherwise permitted.
- R12: If a software write to a counter and an increment of that counter fall in the same cycle, the counter takes the written value and no overflow flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_ns | input | 1 | Access is non-secure |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| evt_in | input | NUM_EVT | Event pulses |
| evt_ns | input | NUM_EVT | Security attribute of each event |
| ns_allow_tie | input | 1 | Tie-off that permits non-secure access |
| sec_disable | input | 1 | Security disabled: all accesses permitted |
| irq | output | 1 | Level overflow interrupt |

## Verification
The selector path gets a sweep over every counter and every selector value. In each run, event k is driven for k+1 cycles, so each count is unique to one event and a miswired selector or an out-of-range code shows up as a wrong number. Every filter code is paired with both security attributes, which separates the four filter behaviours from each other. A preload just below the wrap point, together with same-cycle collisions of a write with an increment and of an overflow with a flag clear, fixes the priority rules. Non-secure accesses are tried under each of the three permission sources in turn and with none of them.

// File: rtl/ecb_pkg.sv
package ecb_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;

    // register map (word addresses)
    localparam logic [ADDR_W-1:0] A_CNT_BASE = 5'd0;
    localparam logic [ADDR_W-1:0] A_SEL_BASE = 5'd8;
    localparam logic [ADDR_W-1:0] A_FLT_BASE = 5'd16;
    localparam logic [ADDR_W-1:0] A_CEN_SET  = 5'd24;
    localparam logic [ADDR_W-1:0] A_CEN_CLR  = 5'd25;
    localparam logic [ADDR_W-1:0] A_IEN_SET  = 5'd26;
    localparam logic [ADDR_W-1:0] A_IEN_CLR  = 5'd27;
    localparam logic [ADDR_W-1:0] A_OVS_SET  = 5'd28;
    localparam logic [ADDR_W-1:0] A_OVS_CLR  = 5'd29;
    localparam logic [ADDR_W-1:0] A_CTRL     = 5'd30;
    localparam logic [ADDR_W-1:0] A_ACCESS   = 5'd31;

    typedef enum logic [1:0] {
        FLT_ANY  = 2'd0,
        FLT_SEC  = 2'd1,
        FLT_NSEC = 2'd2,
        FLT_NONE = 2'd3
    } flt_e;

    function automatic logic filter_pass(input flt_e f, input logic is_ns);
        case (f)
            FLT_ANY:  return 1'b1;
            FLT_SEC:  return !is_ns;
            FLT_NSEC: return is_ns;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ecb_access_gate.sv
module ecb_access_gate
    import ecb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_en,
    input  logic              reg_wr,
    input  logic              reg_ns,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              wbit,
    input  logic              ns_allow_tie,
    input  logic              sec_disable,
    output logic              wr_ok,
    output logic              rd_ok,
    output logic              allow_q
);

    logic permitted;

    assign permitted = !reg_ns || allow_q || ns_allow_tie || sec_disable;
    assign wr_ok     = reg_en && reg_wr && permitted;
    assign rd_ok     = reg_en && !reg_wr && permitted;

    always_ff @(posedge clk) begin
        if (rst) begin
            allow_q <= 1'b0;
        end else if (wr_ok && !reg_ns && reg_addr == A_ACCESS) begin
            allow_q <= wbit;
        end
    end

endmodule

// File: rtl/ecb_counter.sv
module ecb_counter
    import ecb_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int NUM_EVT = 6,
    parameter int SEL_W   = 3
) (
    input  logic               clk,
    input  logic               cnt_wr,
    input  logic               sel_wr,
    input  logic               flt_wr,
    input  logic [CNT_W-1:0]   cnt_wdata,
    input  logic [SEL_W-1:0]   sel_wdata,
    input  flt_e               flt_wdata,
    input  logic               count_en,
    input  logic [NUM_EVT-1:0] evt,
    input  logic [NUM_EVT-1:0] evt_ns,
    output logic [CNT_W-1:0]   cnt_q,
    output logic [SEL_W-1:0]   sel_q,
    output flt_e               flt_q,
    output logic               ovf
);

    logic hit;
    logic hit_ns;
    logic bump;

    // selector values without a matching input leave hit low
    always_comb begin
        hit    = 1'b0;
        hit_ns = 1'b0;
        for (int k = 0; k < NUM_EVT; k++) begin
            if (sel_q == SEL_W'(k)) begin
                hit    = evt[k];
                hit_ns = evt_ns[k];
            end
        end
    end

    assign bump = count_en && hit && filter_pass(flt_q, hit_ns);
    assign ovf  = bump && !cnt_wr && (cnt_q == '1);

    // no reset: software must program before use
    always_ff @(posedge clk) begin
        if (cnt_wr) begin
            cnt_q <= cnt_wdata;
        end else if (bump) begin
            cnt_q <= cnt_q + 1'b1;
        end
        if (sel_wr) sel_q <= sel_wdata;
        if (flt_wr) flt_q <= flt_wdata;
    end

endmodule

// File: rtl/ecb_ctrl_regs.sv
module ecb_ctrl_regs
    import ecb_pkg::*;
#(
    parameter int NUM_CNT = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_ok,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [NUM_CNT-1:0] wmask,
    input  logic [NUM_CNT-1:0] ovf,
    output logic [NUM_CNT-1:0] cnten_q,
    output logic [NUM_CNT-1:0] inten_q,
    output logic [NUM_CNT-1:0] ovs_q,
    output logic               glb_en_q,
    output logic               irq
);

    logic [NUM_CNT-1:0] ovs_set;
    logic [NUM_CNT-1:0] ovs_clr;
    logic [NUM_CNT-1:0] ovs_next;

    assign ovs_set  = (wr_ok && reg_addr == A_OVS_SET) ? wmask : '0;
    assign ovs_clr  = (wr_ok && reg_addr == A_OVS_CLR) ? wmask : '0;
    // setting sources win over a clear in the same cycle
    assign ovs_next = (ovs_q & ~ovs_clr) | ovs_set | ovf;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnten_q  <= '0;
            inten_q  <= '0;
            ovs_q    <= '0;
            glb_en_q <= 1'b0;
        end else begin
            ovs_q <= ovs_next;
            if (wr_ok) begin
                case (reg_addr)
                    A_CEN_SET: cnten_q  <= cnten_q | wmask;
                    A_CEN_CLR: cnten_q  <= cnten_q & ~wmask;
                    A_IEN_SET: inten_q  <= inten_q | wmask;
                    A_IEN_CLR: inten_q  <= inten_q & ~wmask;
                    A_CTRL:    glb_en_q <= wmask[0];
                    default: ;
                endcase
            end
        end
    end

    assign irq = |(ovs_q & inten_q);

endmodule

// File: rtl/ecb_bank.sv
module ecb_bank
    import ecb_pkg::*;
#(
    parameter int NUM_CNT = 5,
    parameter int CNT_W   = 32,
    parameter int NUM_EVT = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_en,
    input  logic               reg_wr,
    input  logic               reg_ns,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic [NUM_EVT-1:0] evt_ns,
    input  logic               ns_allow_tie,
    input  logic               sec_disable,
    output logic               irq
);

    localparam int SEL_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

    initial begin
        if (NUM_CNT > 8 || CNT_W > DATA_W || SEL_W > DATA_W)
            $error("ecb_bank: parameters exceed the register map");
    end

    logic               wr_ok;
    logic               rd_ok;
    logic               allow_q;
    logic [NUM_CNT-1:0] cnten_q;
    logic [NUM_CNT-1:0] inten_q;
    logic [NUM_CNT-1:0] ovs_q;
    logic               glb_en_q;
    logic [NUM_CNT-1:0] ovf;
    logic [CNT_W-1:0]   cnt_q [NUM_CNT];
    logic [SEL_W-1:0]   sel_q [NUM_CNT];
    flt_e               flt_q [NUM_CNT];

    ecb_access_gate u_gate (
        .clk          (clk),
        .rst          (rst),
        .reg_en       (reg_en),
        .reg_wr       (reg_wr),
        .reg_ns       (reg_ns),
        .reg_addr     (reg_addr),
        .wbit         (reg_wdata[0]),
        .ns_allow_tie (ns_allow_tie),
        .sec_disable  (sec_disable),
        .wr_ok        (wr_ok),
        .rd_ok        (rd_ok),
        .allow_q      (allow_q)
    );

    ecb_ctrl_regs #(.NUM_CNT(NUM_CNT)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_ok    (wr_ok),
        .reg_addr (reg_addr),
        .wmask    (reg_wdata[NUM_CNT-1:0]),
        .ovf      (ovf),
        .cnten_q  (cnten_q),
        .inten_q  (inten_q),
        .ovs_q    (ovs_q),
        .glb_en_q (glb_en_q),
        .irq      (irq)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        logic cnt_wr, sel_wr, flt_wr;
        assign cnt_wr = wr_ok && reg_addr == A_CNT_BASE + ADDR_W'(g);
        assign sel_wr = wr_ok && reg_addr == A_SEL_BASE + ADDR_W'(g);
        assign flt_wr = wr_ok && reg_addr == A_FLT_BASE + ADDR_W'(g);

        ecb_counter #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_cnt (
            .clk       (clk),
            .cnt_wr    (cnt_wr),
            .sel_wr    (sel_wr),
            .flt_wr    (flt_wr),
            .cnt_wdata (reg_wdata[CNT_W-1:0]),
            .sel_wdata (reg_wdata[SEL_W-1:0]),
            .flt_wdata (flt_e'(reg_wdata[1:0])),
            .count_en  (cnten_q[g] && glb_en_q),
            .evt       (evt_in),
            .evt_ns    (evt_ns),
            .cnt_q     (cnt_q[g]),
            .sel_q     (sel_q[g]),
            .flt_q     (flt_q[g]),
            .ovf       (ovf[g])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (rd_ok) begin
            for (int n = 0; n < NUM_CNT; n++) begin
                if (reg_addr == A_CNT_BASE + ADDR_W'(n)) reg_rdata[CNT_W-1:0] = cnt_q[n];
                if (reg_addr == A_SEL_BASE + ADDR_W'(n)) reg_rdata[SEL_W-1:0] = sel_q[n];
                if (reg_addr == A_FLT_BASE + ADDR_W'(n)) reg_rdata[1:0]       = flt_q[n];
            end
            case (reg_addr)
                A_CEN_SET, A_CEN_CLR: reg_rdata[NUM_CNT-1:0] = cnten_q;
                A_IEN_SET, A_IEN_CLR: reg_rdata[NUM_CNT-1:0] = inten_q;
                A_OVS_SET, A_OVS_CLR: reg_rdata[NUM_CNT-1:0] = ovs_q;
                A_CTRL:               reg_rdata[0]           = glb_en_q;
                A_ACCESS:             reg_rdata[0]           = allow_q;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ecb_bank_chk.sv
module ecb_bank_chk
    import ecb_pkg::*;
#(
    parameter int NUM_CNT = 5,
    parameter int CNT_W   = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_en,
    input logic               reg_wr,
    input logic               reg_ns,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic               ns_allow_tie,
    input logic               sec_disable,
    input logic               irq,
    input logic [NUM_CNT-1:0] cnten,
    input logic [NUM_CNT-1:0] inten,
    input logic [NUM_CNT-1:0] ovs,
    input logic               glb_en,
    input logic               allow_q,
    input logic [NUM_CNT-1:0] ovf,
    input logic [CNT_W-1:0]   cnt [NUM_CNT]
);

    logic wr_any;
    logic past_rst = 1'b0;

    assign wr_any = reg_en && reg_wr;

    always_ff @(posedge clk) past_rst <= rst;

    // R1: state just after reset
    always @(posedge clk) begin
        if (past_rst && !rst) begin
            a_reset_state_r1: assert (cnten == '0 && inten == '0 && ovs == '0 &&
                                      !glb_en && !allow_q && !irq)
                else $error("reset state wrong");
        end
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_hold
        p_hold_disabled_r2: assert property (@(posedge clk) disable iff (rst)
            (!(cnten[g] && glb_en) && !(wr_any && reg_addr == A_CNT_BASE + ADDR_W'(g)))
            |=> $stable(cnt[g]));
    end

    p_wrap_flags_r3: assert property (@(posedge clk) disable iff (rst)
        (|ovf) |=> ((ovs & $past(ovf)) == $past(ovf)));

    p_cnten_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        !(wr_any && reg_addr == A_CEN_CLR) |=> ((cnten & $past(cnten)) == $past(cnten)));

    p_irq_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (irq && !(wr_any && (reg_addr == A_IEN_CLR || reg_addr == A_OVS_CLR))) |=> irq);

    p_ns_read_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_en && !reg_wr && reg_ns && !allow_q && !ns_allow_tie && !sec_disable)
        |-> (reg_rdata == '0));

    p_allow_secure_only_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_any && reg_ns) |=> $stable(allow_q));

endmodule

bind ecb_bank ecb_bank_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .reg_en       (reg_en),
    .reg_wr       (reg_wr),
    .reg_ns       (reg_ns),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata),
    .ns_allow_tie (ns_allow_tie),
    .sec_disable  (sec_disable),
    .irq          (irq),
    .cnten        (cnten_q),
    .inten        (inten_q),
    .ovs          (ovs_q),
    .glb_en       (glb_en_q),
    .allow_q      (allow_q),
    .ovf          (ovf),
    .cnt          (cnt_q)
);

// File: tb/ecb_bank_tb_top.sv
module ecb_bank_tb_top;

    localparam int NE = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_en = 1'b0, reg_wr = 1'b0, reg_ns = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NE-1:0] evt_in = '0, evt_ns = '0;
    logic        ns_allow_tie = 1'b0, sec_disable = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ecb_bank dut_i (
        .clk(clk), .rst(rst), .reg_en(reg_en), .reg_wr(reg_wr), .reg_ns(reg_ns),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_in(evt_in), .evt_ns(evt_ns), .ns_allow_tie(ns_allow_tie),
        .sec_disable(sec_disable), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic ns);
        @(negedge clk);
        reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_ns = ns;
        @(negedge clk);
        reg_en = 1'b0; reg_wr = 1'b0; reg_ns = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic ns, output logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_wr = 1'b0; reg_addr = a; reg_ns = ns;
        #1 d = reg_rdata;
        reg_en = 1'b0; reg_ns = 1'b0;
    endtask

    task automatic pulse(input logic [NE-1:0] m, input logic [NE-1:0] nsm, input int cyc);
        @(negedge clk);
        evt_in = m; evt_ns = nsm;
        repeat (cyc) @(negedge clk);
        evt_in = '0; evt_ns = '0;
    endtask

    task automatic irq_chk(input string tag, input logic exp);
        @(negedge clk);
        #1 chk(tag, {31'b0, irq}, {31'b0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, prev;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        for (int a = 24; a < 32; a++) begin
            rd(5'(a), 1'b0, d);
            chk($sformatf("R1 reset reg %0d", a), d, 32'h0);
        end
        irq_chk("R1 irq after reset", 1'b0);

        // R2/R9 sweep over counters and selector codes
        wr(5'd30, 32'h1, 1'b0);
        for (int n = 0; n < 5; n++) begin
            for (int s = 0; s < 8; s++) begin
                wr(5'(n), 32'h0, 1'b0);
                wr(5'(8 + n), 32'(s), 1'b0);
                wr(5'(16 + n), 32'h0, 1'b0);
                rd(5'((n + 1) % 5), 1'b0, prev);
                wr(5'd24, 32'(1 << n), 1'b0);
                for (int k = 0; k < NE; k++) pulse(NE'(1 << k), '0, k + 1);
                wr(5'd25, 32'(1 << n), 1'b0);
                rd(5'(n), 1'b0, d);
                chk($sformatf("R2 R9 cnt%0d sel%0d", n, s), d, (s < NE) ? 32'(s + 1) : 32'h0);
                rd(5'((n + 1) % 5), 1'b0, d);
                chk($sformatf("R2 idle cnt%0d", (n + 1) % 5), d, prev);
            end
        end
        wr(5'd29, 32'h1F, 1'b0);

        // R2 both enables needed
        wr(5'd0, 32'h0, 1'b0); wr(5'd8, 32'h0, 1'b0); wr(5'd16, 32'h0, 1'b0);
        pulse(6'h01, '0, 3);
        rd(5'd0, 1'b0, d); chk("R2 no count enable", d, 32'h0);
        wr(5'd24, 32'h1, 1'b0); wr(5'd30, 32'h0, 1'b0);
        pulse(6'h01, '0, 3);
        rd(5'd0, 1'b0, d); chk("R2 no global enable", d, 32'h0);
        wr(5'd30, 32'h1, 1'b0);
        pulse(6'h01, '0, 3);
        rd(5'd0, 1'b0, d); chk("R2 both enables", d, 32'h3);

        // R8 filter codes x event attribute
        wr(5'd9, 32'h2, 1'b0); wr(5'd24, 32'h2, 1'b0);
        for (int f = 0; f < 4; f++) begin
            for (int ns = 0; ns < 2; ns++) begin
                logic pass;
                pass = (f == 0) || (f == 1 && ns == 0) || (f == 2 && ns == 1);
                wr(5'd1, 32'h0, 1'b0);
                wr(5'd17, 32'(f), 1'b0);
                pulse(6'h04, NE'(ns << 2), 2);
                rd(5'd1, 1'b0, d);
                chk($sformatf("R8 filter %0d ns %0d", f, ns), d, pass ? 32'h2 : 32'h0);
            end
        end

        // R3 wrap and flags, R5 R6 R7 interrupt
        wr(5'd29, 32'h1F, 1'b0);
        wr(5'd10, 32'h0, 1'b0); wr(5'd18, 32'h0, 1'b0);
        wr(5'd2, 32'hFFFF_FFFE, 1'b0); wr(5'd24, 32'h4, 1'b0);
        pulse(6'h01, '0, 3);
        rd(5'd2, 1'b0, d); chk("R3 wrapped value", d, 32'h1);
        rd(5'd28, 1'b0, d); chk("R3 overflow flag", d, 32'h4);
        irq_chk("R7 irq masked", 1'b0);
        wr(5'd26, 32'h4, 1'b0);
        rd(5'd27, 1'b0, d); chk("R5 inten set", d, 32'h4);
        irq_chk("R7 irq on enable", 1'b1);
        repeat (4) @(negedge clk);
        irq_chk("R7 irq held", 1'b1);
        wr(5'd27, 32'h4, 1'b0);
        irq_chk("R5 irq off after inten clear", 1'b0);
        wr(5'd26, 32'h4, 1'b0);
        wr(5'd29, 32'h4, 1'b0);
        rd(5'd28, 1'b0, d); chk("R6 flag cleared", d, 32'h0);
        irq_chk("R7 irq off after flag clear", 1'b0);
        wr(5'd28, 32'h8, 1'b0);
        irq_chk("R7 sw flag no enable", 1'b0);
        wr(5'd26, 32'h8, 1'b0);
        irq_chk("R7 sw flag raises irq", 1'b1);
        rd(5'd29, 1'b0, d); chk("R6 sw set flag", d, 32'h8);
        wr(5'd29, 32'h8, 1'b0);

        // R4 zero bits have no effect
        rd(5'd24, 1'b0, prev);
        wr(5'd24, 32'h0, 1'b0);
        rd(5'd24, 1'b0, d); chk("R4 set with zeros", d, prev);
        wr(5'd25, 32'h0, 1'b0);
        rd(5'd25, 1'b0, d); chk("R4 clear with zeros", d, prev);
        wr(5'd25, 32'h4, 1'b0);
        rd(5'd24, 1'b0, d); chk("R4 clear one bit", d, prev & ~32'h4);

        // R12 write beats increment
        wr(5'd11, 32'h0, 1'b0); wr(5'd19, 32'h0, 1'b0); wr(5'd24, 32'h8, 1'b0);
        wr(5'd3, 32'hFFFF_FFFF, 1'b0);
        @(negedge clk);
        evt_in = 6'h01; reg_en = 1'b1; reg_wr = 1'b1; reg_addr = 5'd3; reg_wdata = 32'h5;
        @(negedge clk);
        evt_in = '0; reg_en = 1'b0; reg_wr = 1'b0;
        rd(5'd3, 1'b0, d); chk("R12 written value kept", d, 32'h5);
        rd(5'd28, 1'b0, d); chk("R12 no flag", d, 32'h0);

        // R6 overflow beats same-cycle clear
        wr(5'd3, 32'hFFFF_FFFF, 1'b0);
        @(negedge clk);
        evt_in = 6'h01; reg_en = 1'b1; reg_wr = 1'b1; reg_addr = 5'd29; reg_wdata = 32'h8;
        @(negedge clk);
        evt_in = '0; reg_en = 1'b0; reg_wr = 1'b0;
        rd(5'd28, 1'b0, d); chk("R6 overflow wins clear", d, 32'h8);
        rd(5'd3, 1'b0, d); chk("R3 wrap to zero", d, 32'h0);
        wr(5'd29, 32'h1F, 1'b0);

        // R10 R11 non-secure gate
        rd(5'd30, 1'b1, d); chk("R10 ns read blocked", d, 32'h0);
        wr(5'd30, 32'h0, 1'b1);
        rd(5'd30, 1'b0, d); chk("R10 ns write blocked", d, 32'h1);
        ns_allow_tie = 1'b1;
        rd(5'd30, 1'b1, d); chk("R10 tie allows read", d, 32'h1);
        wr(5'd31, 32'h1, 1'b1);
        rd(5'd31, 1'b0, d); chk("R11 ns cannot set allow", d, 32'h0);
        wr(5'd30, 32'h0, 1'b1);
        rd(5'd30, 1'b0, d); chk("R10 tie allows write", d, 32'h0);
        wr(5'd30, 32'h1, 1'b0);
        ns_allow_tie = 1'b0;
        sec_disable = 1'b1;
        rd(5'd30, 1'b1, d); chk("R10 sec disable allows", d, 32'h1);
        sec_disable = 1'b0;
        wr(5'd31, 32'h1, 1'b0);
        rd(5'd30, 1'b1, d); chk("R10 allow bit permits", d, 32'h1);
        wr(5'd31, 32'h0, 1'b1);
        rd(5'd31, 1'b1, d); chk("R11 ns cannot clear allow", d, 32'h1);
        wr(5'd31, 32'h0, 1'b0);
        rd(5'd30, 1'b1, d); chk("R10 blocked again", d, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule